// File: doc/BRIEF.md
# Single-Precision Float Comparator

This block orders two IEEE-754 single-precision values and reports the relation as a small bit-vector rather than a coded value. Separate bits say whether operand A is below, equal to, above, or unordered with respect to operand B. Two further bits mark operands that are subnormal. Subnormals are compared at their true magnitude and are never treated as zero.

The comparison is quiet. Any NaN makes the pair unordered. Only a signalling NaN raises the invalid indication, and a quiet NaN raises nothing. A request is presented with `in_valid` together with both operands. One clock later the block presents the registered result word with `out_valid`. Between requests the result word keeps its last value.

Top module: `fcmp_sp`

## Requirements
- R1: When out_valid is high, exactly one of result bits 0..3 is set: bit 0 means A < B, bit 1 means A == B, bit 2 means A > B, and bit 3 means unordered.
- R2: Result bit 4 is set exactly when operand A is subnormal, meaning exponent field [30:23] is zero and fraction field [22:0] is nonzero.
- R3: Result bit 5 is set exactly when operand B is subnormal, using the same field test as R2.
- R4: Subnormal operands are ordered by their true value. A subnormal is never flushed to zero: a positive subnormal is greater than zero, and two subnormals order by magnitude and sign.
- R5: An operand is a NaN when exponent [30:23] is all ones and fraction [22:0] is nonzero. Any NaN operand gives unordered. `invalid` is raised with the result only when an operand is signalling, meaning fraction bit 22 is zero. A quiet NaN, with fraction bit 22 set, leaves `invalid` low.
- R6: +0 (0x00000000) and -0 (0x80000000) compare equal.
- R7: Result bits 31..6 are always zero.
- R8: `out_valid` follows `in_valid` by exactly one clock. The result word changes only in the cycle after `in_valid` and otherwise holds its value.
- R9: After a synchronous active-low reset, `out_valid`, `invalid` and the result word are all zero.
- R10: Infinities order like ordinary values: +inf equals +inf, and -inf is below every finite value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | 32 | Operand A, single-precision |
| op_b | input | 32 | Operand B, single-precision |
| out_valid | output | 1 | Result word valid |
| result | output | 32 | Relation bits [3:0], subnormal marks [5:4], zero above |
| invalid | output | 1 | Signalling NaN seen in the reported pair |

## Verification
The bench targets sign handling around zero. A design that compares raw bit patterns would call +0 and -0 unequal, and would misorder two negative values. It also checks pairs of subnormals and subnormal-against-zero cases, where a flushing design would report equal. Quiet and signalling NaNs are driven separately, because a design that decodes the quiet bit wrongly would raise `invalid` on the wrong NaN kind. Idle cycles with changing operands show whether the result word is wrongly updated without `in_valid`.

// File: rtl/fcmp_pkg.sv
// Shared field widths and result bit positions for the float comparator.
package fcmp_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;

    // Result bit positions
    localparam int BIT_LT  = 0;
    localparam int BIT_EQ  = 1;
    localparam int BIT_GT  = 2;
    localparam int BIT_UN  = 3;
    localparam int BIT_DNA = 4;
    localparam int BIT_DNB = 5;
    localparam int USED_W  = 6;

    // Classification of one operand
    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_zero;
        logic is_sub;
    } opclass_t;
endpackage

// File: rtl/fcmp_classify.sv
// Classifies one floating-point operand as NaN (and signalling or not),
// zero, or subnormal. Assumes the layout sign | exponent | fraction with the
// quiet bit as the top fraction bit.
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EW = 8,
    parameter int FW = 23,
    localparam int W = 1 + EW + FW
) (
    input  logic [W-1:0] operand,
    output opclass_t     cls
);
    logic [EW-1:0] exp_f;
    logic [FW-1:0] frac_f;

    // Split fields and decode the class
    always_comb begin
        exp_f        = operand[W-2 -: EW];
        frac_f       = operand[FW-1:0];
        cls.is_nan   = (&exp_f) && (|frac_f);
        cls.is_snan  = (&exp_f) && (|frac_f) && !frac_f[FW-1];
        cls.is_zero  = (exp_f == '0) && (frac_f == '0);
        cls.is_sub   = (exp_f == '0) && (|frac_f);
    end
endmodule

// File: rtl/fcmp_order.sv
// Orders two sign-magnitude floats. The operands are mapped to unsigned keys
// so that the key order matches numeric order. Zero of either sign and
// NaN are handled ahead of the key compare. Assumes the class inputs
// match the operands.
module fcmp_order #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_nan,
    input  logic         b_nan,
    input  logic         a_zero,
    input  logic         b_zero,
    output logic         lt,
    output logic         eq,
    output logic         gt,
    output logic         un
);
    logic [W-1:0] key_a, key_b;

    // Map sign-magnitude to a monotone unsigned key
    always_comb begin
        key_a = a[W-1] ? ~a : {1'b1, a[W-2:0]};
        key_b = b[W-1] ? ~b : {1'b1, b[W-2:0]};
    end

    // Pick exactly one relation
    always_comb begin
        lt = 1'b0; eq = 1'b0; gt = 1'b0; un = 1'b0;
        if (a_nan || b_nan)        un = 1'b1;
        else if (a_zero && b_zero) eq = 1'b1;
        else if (key_a < key_b)    lt = 1'b1;
        else if (key_a > key_b)    gt = 1'b1;
        else                       eq = 1'b1;
    end
endmodule

// File: rtl/fcmp_sp.sv
// Single-precision quiet comparator with a one-stage registered result.
// Result word: [3:0] relation (lt, eq, gt, unordered), [4]/[5] subnormal
// marks for A/B, all higher bits zero. invalid flags a signalling NaN.
// Assumes synchronous active-low reset; the result holds between requests.
module fcmp_sp
    import fcmp_pkg::*;
#(
    parameter int RES_W = 32,
    localparam int W = 1 + EXP_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    output logic             out_valid,
    output logic [RES_W-1:0] result,
    output logic             invalid
);
    logic [W-1:0]     ops [2];
    opclass_t         cls [2];
    logic             r_lt, r_eq, r_gt, r_un;
    logic [RES_W-1:0] res_next;
    logic             inv_next;

    // Gather operands for the classifier array
    always_comb begin
        ops[0] = op_a;
        ops[1] = op_b;
    end

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fcmp_classify #(.EW(EXP_W), .FW(FRAC_W)) u_cls (
            .operand (ops[i]),
            .cls     (cls[i])
        );
    end

    fcmp_order #(.W(W)) u_order (
        .a      (op_a),
        .b      (op_b),
        .a_nan  (cls[0].is_nan),
        .b_nan  (cls[1].is_nan),
        .a_zero (cls[0].is_zero),
        .b_zero (cls[1].is_zero),
        .lt     (r_lt),
        .eq     (r_eq),
        .gt     (r_gt),
        .un     (r_un)
    );

    // Assemble the next result word and the invalid indication
    always_comb begin
        res_next          = '0;
        res_next[BIT_LT]  = r_lt;
        res_next[BIT_EQ]  = r_eq;
        res_next[BIT_GT]  = r_gt;
        res_next[BIT_UN]  = r_un;
        res_next[BIT_DNA] = cls[0].is_sub;
        res_next[BIT_DNB] = cls[1].is_sub;
        inv_next          = cls[0].is_snan || cls[1].is_snan;
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            invalid   <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            invalid   <= in_valid && inv_next;
            if (in_valid) result <= res_next;
        end
    end
endmodule

// File: rtl/fcmp_sp_chk.sv
// Property checker for fcmp_sp, bound to every instance of it.
module fcmp_sp_chk #(
    parameter int RES_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [31:0]      op_a,
    input logic [31:0]      op_b,
    input logic             out_valid,
    input logic [RES_W-1:0] result,
    input logic             invalid
);
    // R1
    relation_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(result[3:0]) == 1);
    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result[RES_W-1:6] == '0);
    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R8
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));
    // R5
    invalid_unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> (out_valid && result[3]));
    // R2
    sub_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> result[4] == ($past(op_a[30:23]) == 8'd0 && $past(op_a[22:0]) != 23'd0));
    // R3
    sub_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> result[5] == ($past(op_b[30:23]) == 8'd0 && $past(op_b[22:0]) != 23'd0));
endmodule

bind fcmp_sp fcmp_sp_chk #(.RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result),
    .invalid   (invalid)
);

// File: tb/fcmp_sp_test.sv
module fcmp_sp_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        out_valid, invalid;
    logic [31:0] result;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    fcmp_sp uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .result(result), .invalid(invalid)
    );

    // {a, b, expected [5:0] = {subB, subA, un, gt, eq, lt}, expected invalid}
    localparam int NV = 16;
    localparam logic [70:0] VECS [NV] = '{
        {32'h3F800000, 32'h40000000, 6'b000001, 1'b0}, // R1 1 < 2
        {32'h40000000, 32'h3F800000, 6'b000100, 1'b0}, // R1 2 > 1
        {32'h3F800000, 32'h3F800000, 6'b000010, 1'b0}, // R1 equal
        {32'hBF800000, 32'h3F800000, 6'b000001, 1'b0}, // R1 -1 < 1
        {32'hC0000000, 32'hBF800000, 6'b000001, 1'b0}, // R1 -2 < -1
        {32'h00000000, 32'h80000000, 6'b000010, 1'b0}, // R6 +0 == -0
        {32'h00000001, 32'h00000002, 6'b110001, 1'b0}, // R4 sub < sub
        {32'h00000001, 32'h00000000, 6'b010100, 1'b0}, // R2 R4 sub > 0
        {32'h00000000, 32'h80000001, 6'b100100, 1'b0}, // R3 R4 0 > -sub
        {32'h7F800000, 32'h7F800000, 6'b000010, 1'b0}, // R10 inf == inf
        {32'hFF800000, 32'h7F7FFFFF, 6'b000001, 1'b0}, // R10 -inf < max
        {32'h7FC00000, 32'h3F800000, 6'b001000, 1'b0}, // R5 qNaN
        {32'h3F800000, 32'h7F800001, 6'b001000, 1'b1}, // R5 sNaN
        {32'hFFC00001, 32'hFFC00001, 6'b001000, 1'b0}, // R5 qNaN pair
        {32'h007FFFFF, 32'h00800000, 6'b010001, 1'b0}, // R2 R4 sub < min normal
        {32'h807FFFFF, 32'h80000001, 6'b110001, 1'b0}  // R4 negative subs
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9", {out_valid, invalid}, 32'd0);
        check("R9", result, 32'd0);
        rst_n = 1'b1;

        // Vector table, back-to-back requests
        for (int i = 0; i < NV; i++) begin
            op_a = VECS[i][70:39];
            op_b = VECS[i][38:7];
            in_valid = 1'b1;
            @(negedge clk);
            check("R8", {31'd0, out_valid}, 32'd1);
            check("R1 R7", result, {26'd0, VECS[i][6:1]});
            check("R5", {31'd0, invalid}, {31'd0, VECS[i][0]});
        end

        // R8 idle: result holds while operands change
        in_valid = 1'b0;
        op_a = 32'h40000000;
        op_b = 32'h7F800001;
        @(negedge clk);
        check("R8", {31'd0, out_valid}, 32'd0);
        check("R8", result, 32'h00000031);
        check("R5", {31'd0, invalid}, 32'd0);
        @(negedge clk);
        check("R8", result, 32'h00000031);

        // R5 signalling NaN on A, negative sign
        op_a = 32'hFF800005; op_b = 32'h00000000; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R5", result, 32'h00000008);
        check("R5", {31'd0, invalid}, 32'd1);
        @(negedge clk);
        check("R5", {31'd0, invalid}, 32'd0);

        // R9 reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", result, 32'd0);
        check("R9", {out_valid, invalid}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule